// File: doc/BRIEF.md
# Data Bus Inversion Encoder and Decoder

This block sits between a core and a wide active-low parallel data bus. It limits how many wires are pulled low in any one transfer phase. The 64-bit word is divided into four 16-bit lanes. The bus values on the ports are given at logical level, and a logical 1 stands for a wire held low. On the send side, the encoder counts the ones in each lane. If a lane holds more than half of its width in ones, the encoder inverts that lane. It then drives the lane's active-low flag low next to the data.

On the receive side, the decoder reads the four flags that arrive with a bus word. It inverts back every lane whose flag is low and passes the other lanes through unchanged. Each phase is handled alone and nothing carries from one phase to the next. Both paths register their outputs, so each has one clock of latency. There are no states to sequence: each path is a single registered stage, and its valid bit either loads the stage or leaves it holding.

Top module: `dbi_codec`

## Requirements
- R1: Flag bit k of `tx_flag_n_o` and `rx_flag_n_i` covers bus bits [16k+15:16k] for k = 0..3, and each lane's decision uses only the bits of that lane.
- R2: On send, a lane with 9 or more ones (wires low) is driven inverted, and its flag bit is 0.
- R3: On send, a lane with 8 or fewer ones is driven unchanged, and its flag bit is 1. This includes the case of exactly 8 ones.
- R4: Every lane of a valid encoded word carries at most 8 ones.
- R5: On receive, each lane whose flag bit is 0 is inverted, and each lane whose flag bit is 1 is passed unchanged.
- R6: Feeding an encoded word and its flags into the receive path returns the original 64-bit word exactly.
- R7: `tx_valid_o` and `rx_valid_o` follow `tx_valid_i` and `rx_valid_i` one clock later, and the data and flags that go with them appear in the same cycle.
- R8: Words presented on consecutive cycles are each encoded from their own content alone, with no influence from the word before.
- R9: While `rst_n` is low, both valid outputs are 0, `tx_flag_n_o` is 4'b1111, and the data outputs are 0.
- R10: A cycle in which an input valid is low leaves that path's data and flag outputs unchanged, whatever data is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Send word present |
| tx_data_i | input | 64 | Send word, logical data |
| tx_valid_o | output | 1 | Encoded word valid |
| tx_bus_o | output | 64 | Encoded bus word (1 = wire low) |
| tx_flag_n_o | output | 4 | Active-low per-lane inversion flags |
| rx_valid_i | input | 1 | Received word present |
| rx_bus_i | input | 64 | Received bus word (1 = wire low) |
| rx_flag_n_i | input | 4 | Received active-low inversion flags |
| rx_valid_o | output | 1 | Restored word valid |
| rx_data_o | output | 64 | Restored logical data |

## Verification
The assertions check several properties on every cycle. They check the low-wire limit on each encoded lane, and that a low flag means the lane is the inverse of the word loaded one clock earlier. They check that each restored lane matches its received lane under its flag, and the one-cycle valid latency. Other behaviours can only be shown by the bench's scenarios. These are the exact threshold at 8 versus 9 ones, the lane-to-flag mapping, the full round trip, back-to-back independence, holding when valid is low, and the reset values.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 16;

    typedef enum logic {
        FLAG_INVERTED = 1'b0,
        FLAG_PLAIN    = 1'b1
    } flag_n_e;
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
    import dbi_pkg::*;
#(
    parameter int W = DEF_LANE_W
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] bus_o,
    output logic         flip_n_o
);
    localparam int CW    = $clog2(W + 1);
    localparam int LIMIT = W / 2;

    logic [CW-1:0] low_cnt;

    always_comb begin
        low_cnt = '0;
        for (int b = 0; b < W; b++) begin
            low_cnt = low_cnt + CW'(raw_i[b]);
        end
    end

    always_comb begin
        if (low_cnt > CW'(LIMIT)) begin
            flip_n_o = FLAG_INVERTED;
            bus_o    = ~raw_i;
        end else begin
            flip_n_o = FLAG_PLAIN;
            bus_o    = raw_i;
        end
    end
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec
    import dbi_pkg::*;
#(
    parameter int W = DEF_LANE_W
) (
    input  logic [W-1:0] bus_i,
    input  logic         flip_n_i,
    output logic [W-1:0] data_o
);
    always_comb begin
        if (flip_n_i == FLAG_INVERTED) begin
            data_o = ~bus_i;
        end else begin
            data_o = bus_i;
        end
    end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_pkg::*;
#(
    parameter  int LANES  = DEF_LANES,
    parameter  int LANE_W = DEF_LANE_W,
    localparam int BUS_W  = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid_i,
    input  logic [BUS_W-1:0] tx_data_i,
    output logic             tx_valid_o,
    output logic [BUS_W-1:0] tx_bus_o,
    output logic [LANES-1:0] tx_flag_n_o,
    input  logic             rx_valid_i,
    input  logic [BUS_W-1:0] rx_bus_i,
    input  logic [LANES-1:0] rx_flag_n_i,
    output logic             rx_valid_o,
    output logic [BUS_W-1:0] rx_data_o
);
    localparam int LIMIT = LANE_W / 2;

    logic [BUS_W-1:0] enc_bus;
    logic [LANES-1:0] enc_flag_n;
    logic [BUS_W-1:0] dec_data;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dbi_lane_enc #(.W(LANE_W)) u_enc (
            .raw_i    (tx_data_i[k*LANE_W +: LANE_W]),
            .bus_o    (enc_bus[k*LANE_W +: LANE_W]),
            .flip_n_o (enc_flag_n[k])
        );

        dbi_lane_dec #(.W(LANE_W)) u_dec (
            .bus_i    (rx_bus_i[k*LANE_W +: LANE_W]),
            .flip_n_i (rx_flag_n_i[k]),
            .data_o   (dec_data[k*LANE_W +: LANE_W])
        );

        // R4
        lane_low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid_o |-> ($countones(tx_bus_o[k*LANE_W +: LANE_W]) <= LIMIT));

        // R2
        flag_means_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && tx_valid_o && !tx_flag_n_o[k]) |->
            (tx_bus_o[k*LANE_W +: LANE_W] == ~$past(tx_data_i[k*LANE_W +: LANE_W])));

        // R5
        rx_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && rx_valid_o) |->
            (rx_data_o[k*LANE_W +: LANE_W] ==
             ($past(rx_flag_n_i[k]) ? $past(rx_bus_i[k*LANE_W +: LANE_W])
                                    : ~$past(rx_bus_i[k*LANE_W +: LANE_W]))));
    end

    // Send stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid_o  <= 1'b0;
            tx_bus_o    <= '0;
            tx_flag_n_o <= '1;
        end else begin
            tx_valid_o <= tx_valid_i;
            if (tx_valid_i) begin
                tx_bus_o    <= enc_bus;
                tx_flag_n_o <= enc_flag_n;
            end
        end
    end

    // Receive stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            rx_valid_o <= rx_valid_i;
            if (rx_valid_i) begin
                rx_data_o <= dec_data;
            end
        end
    end

    // R7
    tx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tx_valid_o == $past(tx_valid_i)));

    // R7
    rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_valid_o == $past(rx_valid_i)));

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tx_valid_i)) |-> ($stable(tx_bus_o) && $stable(tx_flag_n_o)));
endmodule

// File: tb/dbi_codec_test.sv
module dbi_codec_test;
    logic        clk;
    logic        rst_n;
    logic        tx_valid_i;
    logic [63:0] tx_data_i;
    logic        tx_valid_o;
    logic [63:0] tx_bus_o;
    logic [3:0]  tx_flag_n_o;
    logic        rx_valid_i;
    logic [63:0] rx_bus_i;
    logic [3:0]  rx_flag_n_i;
    logic        rx_valid_o;
    logic [63:0] rx_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    dbi_codec uut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
        .tx_valid_o(tx_valid_o), .tx_bus_o(tx_bus_o), .tx_flag_n_o(tx_flag_n_o),
        .rx_valid_i(rx_valid_i), .rx_bus_i(rx_bus_i), .rx_flag_n_i(rx_flag_n_i),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Lanes: FFFF=16 ones, 01FF=9, 00FF=8, FF00=8, 7FFF=15, FFFE=15, 1234=5
    localparam int NV = 5;
    localparam logic [63:0] V_DATA [NV] = '{
        64'hFFFF_01FF_00FF_0000,
        64'h0000_00FF_01FF_FFFF,
        64'h7FFF_FF00_1234_FFFE,
        64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF
    };
    localparam logic [63:0] V_BUS [NV] = '{
        64'h0000_FE00_00FF_0000,
        64'h0000_00FF_FE00_0000,
        64'h8000_FF00_1234_0001,
        64'h0000_0000_0000_0000,
        64'h0000_0000_0000_0000
    };
    localparam logic [3:0] V_FLG [NV] = '{
        4'b0011, 4'b1100, 4'b0110, 4'b1111, 4'b0000
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] word, bus;
        logic [3:0]  flg;
        rst_n = 1'b1;
        tx_valid_i = 0; tx_data_i = '0;
        rx_valid_i = 0; rx_bus_i = '0; rx_flag_n_i = '1;
        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset values
        chk("R9 tx_valid", 64'(tx_valid_o), 64'd0);
        chk("R9 tx_flag", 64'(tx_flag_n_o), 64'hF);
        chk("R9 tx_bus", tx_bus_o, 64'd0);
        chk("R9 rx_valid", 64'(rx_valid_o), 64'd0);
        chk("R9 rx_data", rx_data_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk, back to back on both paths (R1 R2 R3 R5 R7 R8)
        tx_valid_i = 1; tx_data_i = V_DATA[0];
        rx_valid_i = 1; rx_bus_i = V_BUS[0]; rx_flag_n_i = V_FLG[0];
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk("R7 tx_valid", 64'(tx_valid_o), 64'd1);
            chk("R2/R3 tx_bus", tx_bus_o, V_BUS[i]);
            chk("R1/R2/R3 tx_flag", 64'(tx_flag_n_o), 64'(V_FLG[i]));
            chk("R7 rx_valid", 64'(rx_valid_o), 64'd1);
            chk("R5/R8 rx_data", rx_data_o, V_DATA[i]);
            if (i < NV - 1) begin
                tx_data_i = V_DATA[i+1];
                rx_bus_i = V_BUS[i+1]; rx_flag_n_i = V_FLG[i+1];
            end else begin
                tx_valid_i = 0; tx_data_i = 64'hFFFF_0000_FFFF_0000;
                rx_valid_i = 0; rx_bus_i = 64'h1111_2222_3333_4444; rx_flag_n_i = 4'b0101;
            end
        end
        // R10 hold while valid is low
        @(negedge clk);
        chk("R10 tx_valid", 64'(tx_valid_o), 64'd0);
        chk("R10 tx_bus", tx_bus_o, V_BUS[NV-1]);
        chk("R10 tx_flag", 64'(tx_flag_n_o), 64'(V_FLG[NV-1]));
        chk("R10 rx_valid", 64'(rx_valid_o), 64'd0);
        chk("R10 rx_data", rx_data_o, V_DATA[NV-1]);

        // R1 single-lane isolation: only lane 2 over threshold
        tx_valid_i = 1; tx_data_i = 64'h00FF_03FF_00FF_00FF;
        @(negedge clk);
        tx_valid_i = 0;
        chk("R1 lane2 only bus", tx_bus_o, 64'h00FF_FC00_00FF_00FF);
        chk("R1 lane2 only flag", 64'(tx_flag_n_o), 64'b1011);

        // R6 and R4 random round trip
        for (int n = 0; n < 300; n++) begin
            word = {$urandom, $urandom};
            if (n % 3 == 0) word = word | 64'hF0F0_0F0F_FF00_00FF;
            tx_valid_i = 1; tx_data_i = word;
            @(negedge clk);
            tx_valid_i = 0;
            bus = tx_bus_o; flg = tx_flag_n_o;
            for (int k = 0; k < 4; k++) begin
                chk("R4 lane ones<=8", 64'($countones(bus[k*16 +: 16]) <= 8), 64'd1);
            end
            rx_valid_i = 1; rx_bus_i = bus; rx_flag_n_i = flg;
            @(negedge clk);
            rx_valid_i = 0;
            chk("R6 round trip", rx_data_o, word);
        end

        // R9 asynchronous reset mid-run
        tx_valid_i = 1; tx_data_i = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        chk("R9 mid tx_flag", 64'(tx_flag_n_o), 64'hF);
        chk("R9 mid tx_valid", 64'(tx_valid_o), 64'd0);
        chk("R9 mid tx_bus", tx_bus_o, 64'd0);
        chk("R9 mid rx_data", rx_data_o, 64'd0);
        finish_run();
    end
endmodule